// File: doc/BRIEF.md
# Linked-Descriptor Transfer Queue

This block walks a singly linked list of buffer descriptors held in its own descriptor RAM. For each descriptor it places one transfer command on a valid/ready output. The command carries the buffer address, the packet length and the start/end-of-packet flags. It waits for the downstream mover to report the transfer as done, and then writes a status word back into the descriptor. Software owns the list. It fills descriptors through a host port, starts a chain by writing the head register, and acknowledges every completed descriptor through the completion register.

A descriptor is four consecutive RAM words at a word address `p`: `p+0` next pointer, `p+1` buffer address, `p+2` buffer length (kept for software, not read by the engine), `p+3` mode/status word. Pointers are RAM word addresses, and zero terminates the list, so word 0 never holds a descriptor. The next pointer is read only after the transfer finishes. This lets software link a new descriptor onto a running chain. An owner flag and an end-of-queue flag let software tell a finished chain from one that stalled on an unowned descriptor. Software restarts a stalled chain by writing the head register again.

The host port reaches RAM with address bit 6 clear and registers with bit 6 set. The register index is in bits 1:0: 0 control, 1 soft reset, 2 head, 3 completion. Reads return data in the cycle after the request.

Top module: `dq_dma`

## Requirements
- R1: A command carries, on `cmd_buf_o`, the word stored at descriptor address + 1, where the descriptor address is a RAM word address.
- R2: In the mode word, bit 31 is start-of-packet, bit 30 end-of-packet, bit 29 owner and bit 28 end-of-queue. Bits 10:0 are the packet length. The start and end flags appear on `cmd_sop_o` and `cmd_eop_o`.
- R3: `cmd_len_o` is the mode length when it is 60 or more, and 60 when it is below 60.
- R4: Writing a nonzero value to the head register (index 2) while it reads zero starts the chain. A head write while the register is nonzero is ignored. The head register reads zero after reset and after the last descriptor completes.
- R5: On completion the engine rewrites the mode word with the owner bit cleared and all other bits kept. End-of-queue is set only if the next pointer, read after the transfer, is zero.
- R6: After each completion the engine issues nothing further until the host writes that descriptor's address to the completion register (index 3). A write of any other value is ignored. The completion register reads the address of the last completed descriptor.
- R7: A descriptor fetched with the owner bit clear produces no command. Its mode word gets end-of-queue set, and the head register returns to zero.
- R8: A next pointer written into a descriptor while its transfer is in flight is followed without a new head write.
- R9: Control bit 0 enables the engine and is zero after reset. While it is clear, no new descriptor is fetched. Setting it resumes a pending chain.
- R10: Writing 1 to bit 0 of the soft-reset register (index 1) reads back 1 once and then 0. It clears the head, completion and control registers and drops any pending command. Descriptor RAM is kept.
- R11: Host reads return data one cycle after the request. A host RAM access takes precedence over the engine in the same cycle.
- R12: While `cmd_valid_o` is high and `cmd_ready_i` low, the command fields hold steady. `xfer_done_i` has no effect before the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | 7 | Bit 6 selects registers; otherwise RAM word address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read data, valid the cycle after a read |
| cmd_valid_o | output | 1 | Transfer command valid |
| cmd_ready_i | input | 1 | Command accepted by the mover |
| cmd_buf_o | output | 32 | Buffer address of the command |
| cmd_len_o | output | 11 | Padded transfer length |
| cmd_sop_o | output | 1 | Start-of-packet flag |
| cmd_eop_o | output | 1 | End-of-packet flag |
| xfer_done_i | input | 1 | Pulse: accepted transfer finished |

## Verification
A corrupted walker state shows up within a few cycles of the next transfer. The symptoms are a command with the wrong buffer, a missing command, or a mode word written back with the owner bit still set or with the end-of-queue flag wrong. A lost completion address shows up only when software acknowledges: either the engine never resumes, or the completion register reads the wrong address. A dropped next pointer stays hidden until a chain of two or more descriptors ends early and the head register reads zero too soon. This is why chained and appended lists are driven, and not only single descriptors.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int unsigned SOP_BIT = 31;
  localparam int unsigned EOP_BIT = 30;
  localparam int unsigned OWN_BIT = 29;
  localparam int unsigned EOQ_BIT = 28;
  localparam int unsigned LEN_W   = 11;
  localparam int unsigned DW      = 32;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_SRST = 2'd1,
    REG_HEAD = 2'd2,
    REG_CMPL = 2'd3
  } reg_idx_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_BUF, ST_CAP_BUF, ST_RD_MODE, ST_CAP_MODE,
    ST_CMD, ST_XFER, ST_RD_NEXT, ST_CAP_NEXT, ST_WB, ST_ACK
  } walk_st_e;
endpackage

// File: rtl/dq_desc_ram.sv
module dq_desc_ram import dq_pkg::*; #(
  parameter int unsigned WORDS = 64,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_req_i,
  input  logic          h_we_i,
  input  logic [AW-1:0] h_addr_i,
  input  logic [DW-1:0] h_wdata_i,
  input  logic          e_req_i,
  input  logic          e_we_i,
  input  logic [AW-1:0] e_addr_i,
  input  logic [DW-1:0] e_wdata_i,
  output logic          e_gnt_o,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] mem_q [WORDS];
  logic          acc;
  logic          sel_we;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wd;

  // host wins a same-cycle collision; engine retries
  assign e_gnt_o  = e_req_i & ~h_req_i;
  assign acc      = h_req_i | e_gnt_o;
  assign sel_we   = h_req_i ? h_we_i    : e_we_i;
  assign sel_addr = h_req_i ? h_addr_i  : e_addr_i;
  assign sel_wd   = h_req_i ? h_wdata_i : e_wdata_i;

  always_ff @(posedge clk_i) begin
    if (acc && sel_we) mem_q[sel_addr] <= sel_wd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_o <= '0;
    else if (acc && !sel_we)  q_o <= mem_q[sel_addr];
  end
endmodule

// File: rtl/dq_host_regs.sv
module dq_host_regs import dq_pkg::*; #(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_req_i,
  input  logic          host_we_i,
  input  logic          is_reg_i,
  input  logic [1:0]    idx_i,
  input  logic          wbit_i,
  input  logic [AW-1:0] head_i,
  input  logic [AW-1:0] cmpl_i,
  input  logic [DW-1:0] ram_q_i,
  output logic          ram_req_o,
  output logic          en_o,
  output logic          srst_o,
  output logic          head_wr_o,
  output logic          cmpl_wr_o,
  output logic [DW-1:0] host_rdata_o
);
  reg_idx_e      idx;
  logic          reg_wr;
  logic          reg_rd;
  logic          en_q;
  logic          srst_q;
  logic          rd_ram_q;
  logic [DW-1:0] reg_rd_q;

  assign idx       = reg_idx_e'(idx_i);
  assign ram_req_o = host_req_i & ~is_reg_i;
  assign reg_wr    = host_req_i & host_we_i & is_reg_i;
  assign reg_rd    = host_req_i & ~host_we_i & is_reg_i;
  assign head_wr_o = reg_wr && (idx == REG_HEAD);
  assign cmpl_wr_o = reg_wr && (idx == REG_CMPL);
  assign en_o      = en_q;
  assign srst_o    = srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      if (srst_q)                                en_q <= 1'b0;
      else if (reg_wr && idx == REG_CTRL)        en_q <= wbit_i;
      if (srst_q)                                srst_q <= 1'b0;
      else if (reg_wr && idx == REG_SRST && wbit_i) srst_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ram_q <= 1'b0;
      reg_rd_q <= '0;
    end else begin
      rd_ram_q <= host_req_i & ~host_we_i & ~is_reg_i;
      if (reg_rd) begin
        unique case (idx)
          REG_CTRL: reg_rd_q <= {{(DW-1){1'b0}}, en_q};
          REG_SRST: reg_rd_q <= {{(DW-1){1'b0}}, srst_q};
          REG_HEAD: reg_rd_q <= {{(DW-AW){1'b0}}, head_i};
          REG_CMPL: reg_rd_q <= {{(DW-AW){1'b0}}, cmpl_i};
          default:  reg_rd_q <= '0;
        endcase
      end
    end
  end

  assign host_rdata_o = rd_ram_q ? ram_q_i : reg_rd_q;

  a_r9_en_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr && idx == REG_CTRL && !srst_q) |=> (en_o == $past(wbit_i)));
endmodule

// File: rtl/dq_walker.sv
module dq_walker import dq_pkg::*; #(
  parameter int unsigned AW      = 6,
  parameter int unsigned MIN_LEN = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             en_i,
  input  logic             head_wr_i,
  input  logic             cmpl_wr_i,
  input  logic [DW-1:0]    host_wdata_i,
  output logic [AW-1:0]    head_o,
  output logic [AW-1:0]    cmpl_o,
  output logic             ram_req_o,
  output logic             ram_we_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic [DW-1:0]    ram_wdata_o,
  input  logic             ram_gnt_i,
  input  logic [DW-1:0]    ram_q_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [DW-1:0]    cmd_buf_o,
  output logic [LEN_W-1:0] cmd_len_o,
  output logic             cmd_sop_o,
  output logic             cmd_eop_o,
  input  logic             xfer_done_i
);
  localparam logic [AW-1:0]    OFS_BUF  = AW'(1);
  localparam logic [AW-1:0]    OFS_MODE = AW'(3);
  localparam logic [LEN_W-1:0] MIN_L    = LEN_W'(MIN_LEN);

  walk_st_e      st_q;
  logic [AW-1:0] head_q, cmpl_q, next_q;
  logic [DW-1:0] buf_q, mode_q;
  logic          stop_q;
  logic          ack_hit;
  logic [DW-1:0] eoq_mask;

  assign ack_hit = cmpl_wr_i && (host_wdata_i[AW-1:0] == cmpl_q)
                   && (host_wdata_i[DW-1:AW] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; head_q <= '0; cmpl_q <= '0; next_q <= '0;
      buf_q <= '0; mode_q <= '0; stop_q <= 1'b0;
    end else if (srst_i) begin
      st_q <= ST_IDLE; head_q <= '0; cmpl_q <= '0; next_q <= '0;
      buf_q <= '0; mode_q <= '0; stop_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE:     if (en_i && head_q != '0) st_q <= ST_RD_BUF;
        ST_RD_BUF:   if (ram_gnt_i) st_q <= ST_CAP_BUF;
        ST_CAP_BUF: begin
          buf_q <= ram_q_i;
          st_q  <= ST_RD_MODE;
        end
        ST_RD_MODE:  if (ram_gnt_i) st_q <= ST_CAP_MODE;
        ST_CAP_MODE: begin
          mode_q <= ram_q_i;
          stop_q <= ~ram_q_i[OWN_BIT];
          st_q   <= ram_q_i[OWN_BIT] ? ST_CMD : ST_WB;
        end
        ST_CMD:      if (cmd_ready_i) st_q <= ST_XFER;
        ST_XFER:     if (xfer_done_i) st_q <= ST_RD_NEXT;
        ST_RD_NEXT:  if (ram_gnt_i) st_q <= ST_CAP_NEXT;
        ST_CAP_NEXT: begin
          // re-read after the transfer so a late append is seen
          next_q <= ram_q_i[AW-1:0];
          st_q   <= ST_WB;
        end
        ST_WB: if (ram_gnt_i) begin
          if (stop_q) begin
            head_q <= '0;
            st_q   <= ST_IDLE;
          end else begin
            cmpl_q <= head_q;
            head_q <= next_q;
            st_q   <= ST_ACK;
          end
        end
        ST_ACK:      if (ack_hit) st_q <= ST_IDLE;
        default:     st_q <= ST_IDLE;
      endcase
      if (head_wr_i && head_q == '0) head_q <= host_wdata_i[AW-1:0];
    end
  end

  always_comb begin
    eoq_mask = '0;
    eoq_mask[EOQ_BIT] = 1'b1;
  end

  always_comb begin
    ram_req_o   = 1'b0;
    ram_we_o    = 1'b0;
    ram_addr_o  = head_q;
    ram_wdata_o = '0;
    unique case (st_q)
      ST_RD_BUF:  begin ram_req_o = 1'b1; ram_addr_o = head_q + OFS_BUF;  end
      ST_RD_MODE: begin ram_req_o = 1'b1; ram_addr_o = head_q + OFS_MODE; end
      ST_RD_NEXT: begin ram_req_o = 1'b1; ram_addr_o = head_q;            end
      ST_WB: begin
        ram_req_o  = 1'b1;
        ram_we_o   = 1'b1;
        ram_addr_o = head_q + OFS_MODE;
        if (stop_q) ram_wdata_o = mode_q | eoq_mask;
        else begin
          ram_wdata_o = mode_q;
          ram_wdata_o[OWN_BIT] = 1'b0;
          ram_wdata_o[EOQ_BIT] = (next_q == '0);
        end
      end
      default: ;
    endcase
  end

  assign head_o      = head_q;
  assign cmpl_o      = cmpl_q;
  assign cmd_valid_o = (st_q == ST_CMD);
  assign cmd_buf_o   = buf_q;
  assign cmd_len_o   = (mode_q[LEN_W-1:0] < MIN_L) ? MIN_L : mode_q[LEN_W-1:0];
  assign cmd_sop_o   = mode_q[SOP_BIT];
  assign cmd_eop_o   = mode_q[EOP_BIT];

  a_r12_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i && !srst_i) |=>
      (cmd_valid_o && $stable(cmd_buf_o) && $stable(cmd_len_o)));
  a_r3_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_len_o >= MIN_L));
  a_r5_wb_owner_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_req_o && ram_we_o && ram_gnt_i) |-> !ram_wdata_o[OWN_BIT]);
  a_r7_cmd_needs_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> mode_q[OWN_BIT]);
  a_r10_srst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (head_o == '0 && cmpl_o == '0 && !cmd_valid_o));
endmodule

// File: rtl/dq_dma.sv
module dq_dma import dq_pkg::*; #(
  parameter int unsigned RAM_WORDS = 64,
  parameter int unsigned MIN_LEN   = 60,
  localparam int unsigned AW   = $clog2(RAM_WORDS),
  localparam int unsigned HA_W = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_req_i,
  input  logic             host_we_i,
  input  logic [HA_W-1:0]  host_addr_i,
  input  logic [DW-1:0]    host_wdata_i,
  output logic [DW-1:0]    host_rdata_o,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [DW-1:0]    cmd_buf_o,
  output logic [LEN_W-1:0] cmd_len_o,
  output logic             cmd_sop_o,
  output logic             cmd_eop_o,
  input  logic             xfer_done_i
);
  logic          h_ram_req, en, srst, head_wr, cmpl_wr;
  logic [AW-1:0] head, cmpl;
  logic          e_req, e_we, e_gnt;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_wdata, ram_q;

  dq_host_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .host_req_i, .host_we_i,
    .is_reg_i     (host_addr_i[HA_W-1]),
    .idx_i        (host_addr_i[1:0]),
    .wbit_i       (host_wdata_i[0]),
    .head_i       (head),
    .cmpl_i       (cmpl),
    .ram_q_i      (ram_q),
    .ram_req_o    (h_ram_req),
    .en_o         (en),
    .srst_o       (srst),
    .head_wr_o    (head_wr),
    .cmpl_wr_o    (cmpl_wr),
    .host_rdata_o
  );

  dq_desc_ram #(.WORDS(RAM_WORDS)) u_ram (
    .clk_i, .rst_ni,
    .h_req_i   (h_ram_req),
    .h_we_i    (host_we_i),
    .h_addr_i  (host_addr_i[AW-1:0]),
    .h_wdata_i (host_wdata_i),
    .e_req_i   (e_req),
    .e_we_i    (e_we),
    .e_addr_i  (e_addr),
    .e_wdata_i (e_wdata),
    .e_gnt_o   (e_gnt),
    .q_o       (ram_q)
  );

  dq_walker #(.AW(AW), .MIN_LEN(MIN_LEN)) u_walk (
    .clk_i, .rst_ni,
    .srst_i      (srst),
    .en_i        (en),
    .head_wr_i   (head_wr),
    .cmpl_wr_i   (cmpl_wr),
    .host_wdata_i,
    .head_o      (head),
    .cmpl_o      (cmpl),
    .ram_req_o   (e_req),
    .ram_we_o    (e_we),
    .ram_addr_o  (e_addr),
    .ram_wdata_o (e_wdata),
    .ram_gnt_i   (e_gnt),
    .ram_q_i     (ram_q),
    .cmd_valid_o, .cmd_ready_i, .cmd_buf_o, .cmd_len_o,
    .cmd_sop_o, .cmd_eop_o, .xfer_done_i
  );
endmodule

// File: tb/dq_dma_tb_top.sv
module dq_dma_tb_top;
  localparam int HA_W = 7;
  localparam logic [HA_W-1:0] A_CTRL = 7'h40, A_SRST = 7'h41,
                              A_HEAD = 7'h42, A_CMPL = 7'h43;
  localparam logic [31:0] M_SOP = 32'h8000_0000, M_EOP = 32'h4000_0000,
                          M_OWN = 32'h2000_0000, M_EOQ = 32'h1000_0000;
  localparam int V_LEN [6] = '{0, 1, 59, 60, 61, 2047};
  localparam int V_EXP [6] = '{60, 60, 60, 60, 61, 2047};
  localparam int V_FLG [6] = '{3, 2, 1, 0, 3, 2};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            host_req = 1'b0, host_we = 1'b0;
  logic [HA_W-1:0] host_addr = '0;
  logic [31:0]     host_wdata = '0;
  logic [31:0]     host_rdata;
  logic            cmd_valid, cmd_ready = 1'b0, cmd_sop, cmd_eop, xfer_done = 1'b0;
  logic [31:0]     cmd_buf;
  logic [10:0]     cmd_len;

  dq_dma dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_buf_o(cmd_buf),
    .cmd_len_o(cmd_len), .cmd_sop_o(cmd_sop), .cmd_eop_o(cmd_eop),
    .xfer_done_i(xfer_done)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit ended = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    ended = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      wrap_up();
    end
  end

  // all tasks start one time unit after a rising edge
  task automatic hw(logic [HA_W-1:0] a, logic [31:0] d);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic hr(logic [HA_W-1:0] a, output logic [31:0] d);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    @(posedge clk); #1;
    d = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic put_desc(int base, int nxt, logic [31:0] bufa, logic [31:0] mode);
    hw(HA_W'(base), 32'(nxt));
    hw(HA_W'(base + 1), bufa);
    hw(HA_W'(base + 2), 32'(mode[10:0]));
    hw(HA_W'(base + 3), mode);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_cmd();
    for (int i = 0; i < 200 && !cmd_valid; i++) idle(1);
  endtask

  task automatic accept();
    cmd_ready = 1'b1; idle(1); cmd_ready = 1'b0;
  endtask

  task automatic finish_xfer();
    xfer_done = 1'b1; idle(1); xfer_done = 1'b0;
    idle(6);
  endtask

  logic [31:0] rd, mode, hold_buf;
  logic [10:0] hold_len;

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // reset state
    hr(A_HEAD, rd); chk("R4 head after reset", rd, 0);
    hr(A_CTRL, rd); chk("R9 control after reset", rd, 0);
    hr(A_CMPL, rd); chk("R6 completion after reset", rd, 0);
    chk("R12 no command after reset", 32'(cmd_valid), 0);

    // host RAM access
    hw(7'd60, 32'hDEAD_BEEF);
    hr(7'd60, rd); chk("R11 RAM readback", rd, 32'hDEAD_BEEF);

    hw(A_CTRL, 1);

    // vector table: single descriptors, length padding and flags
    for (int i = 0; i < 6; i++) begin
      int base;
      base = 4 * (i + 1);
      mode = M_OWN | (V_FLG[i][1] ? M_SOP : 0) | (V_FLG[i][0] ? M_EOP : 0)
             | 32'(V_LEN[i]) | (32'(i) << 16);
      put_desc(base, 0, 32'hA000_0000 + 32'(i) * 32'h111, mode);
      hw(A_HEAD, 32'(base));
      wait_cmd();
      chk("R4 chain started", 32'(cmd_valid), 1);
      chk("R1 buffer address", cmd_buf, 32'hA000_0000 + 32'(i) * 32'h111);
      chk("R3 padded length", 32'(cmd_len), 32'(V_EXP[i]));
      chk("R2 sop/eop flags", {30'b0, cmd_sop, cmd_eop}, 32'(V_FLG[i]));
      accept();
      finish_xfer();
      hr(HA_W'(base + 3), rd);
      chk("R5 write-back at end of list", rd, (mode & ~M_OWN) | M_EOQ);
      hr(A_HEAD, rd); chk("R4 head zero at end", rd, 0);
      hr(A_CMPL, rd); chk("R6 completion address", rd, 32'(base));
      hw(A_CMPL, 32'(base));
    end

    // hold under backpressure, early done ignored
    put_desc(32, 0, 32'h1234_5678, M_OWN | M_SOP | M_EOP | 32'd100);
    hw(A_HEAD, 32);
    wait_cmd();
    hold_buf = cmd_buf; hold_len = cmd_len;
    xfer_done = 1'b1; idle(1); xfer_done = 1'b0;
    idle(4);
    chk("R12 valid held", 32'(cmd_valid), 1);
    chk("R12 buffer held", cmd_buf, hold_buf);
    chk("R12 length held", 32'(cmd_len), 32'(hold_len));
    accept();
    idle(4);
    hr(7'd35, rd);
    chk("R12 early done ignored", rd, M_OWN | M_SOP | M_EOP | 32'd100);
    finish_xfer();
    hr(7'd35, rd); chk("R5 owner cleared", rd, M_SOP | M_EOP | M_EOQ | 32'd100);
    hw(A_CMPL, 32);

    // two-descriptor chain, wrong ack, head write while busy
    put_desc(48, 0, 32'hC000_0003, M_OWN | 32'd80);
    put_desc(40, 44, 32'hC000_0001, M_OWN | M_SOP | 32'd60);
    put_desc(44, 0, 32'hC000_0002, M_OWN | M_EOP | 32'd70);
    hw(A_HEAD, 40);
    wait_cmd();
    chk("R1 first of chain", cmd_buf, 32'hC000_0001);
    accept();
    finish_xfer();
    hr(7'd43, rd); chk("R5 mid-chain no end-of-queue", rd, M_SOP | 32'd60);
    hr(A_CMPL, rd); chk("R6 completion reads first", rd, 40);
    hw(A_CMPL, 41);
    idle(10);
    chk("R6 wrong ack ignored", 32'(cmd_valid), 0);
    hw(A_CMPL, 40);
    wait_cmd();
    chk("R6 resumes after ack", cmd_buf, 32'hC000_0002);
    hw(A_HEAD, 48);
    accept();
    finish_xfer();
    hr(7'd47, rd); chk("R5 last of chain", rd, M_EOP | M_EOQ | 32'd70);
    hw(A_CMPL, 44);
    idle(10);
    chk("R4 busy head write ignored", 32'(cmd_valid), 0);
    hr(7'd51, rd); chk("R4 untouched descriptor", rd, M_OWN | 32'd80);

    // append while in flight
    put_desc(52, 0, 32'hD000_0004, M_OWN | 32'd90);
    put_desc(56, 0, 32'hD000_0005, M_OWN | 32'd100);
    hw(A_HEAD, 52);
    wait_cmd();
    hw(7'd52, 56);
    accept();
    finish_xfer();
    hr(7'd55, rd); chk("R8 appended: no end-of-queue", rd, 32'd90);
    hw(A_CMPL, 52);
    wait_cmd();
    chk("R8 appended descriptor followed", cmd_buf, 32'hD000_0005);
    accept();
    finish_xfer();
    hw(A_CMPL, 56);
    hr(A_HEAD, rd); chk("R8 head zero after append", rd, 0);

    // unowned descriptor
    put_desc(20, 0, 32'hE000_0006, M_SOP | M_EOP | 32'd64);
    hw(A_HEAD, 20);
    idle(10);
    chk("R7 no command", 32'(cmd_valid), 0);
    hr(7'd23, rd); chk("R7 end-of-queue set", rd, M_SOP | M_EOP | M_EOQ | 32'd64);
    hr(A_HEAD, rd); chk("R7 head zero", rd, 0);

    // enable gating
    hw(A_CTRL, 0);
    put_desc(24, 0, 32'hF000_0007, M_OWN | 32'd120);
    hw(A_HEAD, 24);
    idle(10);
    chk("R9 disabled: no command", 32'(cmd_valid), 0);
    hw(A_CTRL, 1);
    wait_cmd();
    chk("R9 resumed", cmd_buf, 32'hF000_0007);

    // soft reset with a command pending
    hw(A_SRST, 1);
    hr(A_SRST, rd); chk("R10 reset bit set", rd, 1);
    hr(A_SRST, rd); chk("R10 reset bit self-clears", rd, 0);
    chk("R10 command dropped", 32'(cmd_valid), 0);
    hr(A_HEAD, rd); chk("R10 head cleared", rd, 0);
    hr(A_CTRL, rd); chk("R10 enable cleared", rd, 0);
    hr(A_CMPL, rd); chk("R10 completion cleared", rd, 0);
    hw(A_CTRL, 1);
    hw(A_HEAD, 24);
    wait_cmd();
    chk("R10 restart, RAM kept", cmd_buf, 32'hF000_0007);

    wrap_up();
  end
endmodule